// File: doc/BRIEF.md
# Dual Serial Command Port Front-End

This block terminates two independent asynchronous serial ports (8 data bits, no parity, one stop bit, least significant bit first) inside an encoder clocked at 16 MHz. Port 1 runs at a rate picked by a 3-bit code. Port 2 always runs at 19200 bit/s. Both receivers oversample the line at 16 ticks per bit. Each receive input goes through a two-flop synchronizer. A start bit counts only if the line is still low at the middle of the bit.

After every reset, each port transmits a fixed greeting followed by carriage return (0x0D) and line feed (0x0A). Port 1 sends a version text taken from a small parameterised ROM, which defaults to "FE-1.3". Port 2 sends "AT+i".

Each port then waits out its own readiness interval. Until that interval ends, completed bytes are thrown away and counted. Once a port is ready, its bytes go to a command interpreter over a valid/ready stream. Each byte carries its source port and a flag telling whether that port is the local port. An input pin selects which port is the local port. The interpreter never disables commands from the local port.

Top module: `dual_uart_front`

## Requirements
- R1: The port 1 rate code `rateSel` selects 1200 × 2^code bit/s for codes 0..4, and codes 5..7 select 19200 bit/s. The bit time is 16 ticks of a divisor equal to floor(CLK_HZ/(1200·16)) shifted right by the clamped code.
- R2: Port 2 always runs at 19200 bit/s (16 ticks of floor(CLK_HZ/(19200·16)) cycles), whatever the value of `rateSel`.
- R3: Both transmit lines rest at 1 when idle. Frames are one start bit (0), eight data bits with the LSB first, and one stop bit (1).
- R4: After reset, port 1 (`txOut[0]`) sends the VERSION_LEN characters of VERSION_TEXT, first character in the most significant byte, then 0x0D and 0x0A. Port 2 (`txOut[1]`) sends 0x41 0x54 0x2B 0x69 0x0D 0x0A. Both are sent once per reset.
- R5: `portReady[0]` rises READY1_CYC cycles after reset is released and `portReady[1]` rises READY2_CYC cycles after. Once high, each stays high until the next reset.
- R6: A byte that completes on a port whose `portReady` bit is low is never presented on the stream, and it increments that port's drop counter (`dropCnt1` for port 1, `dropCnt2` for port 2).
- R7: A low stop bit discards the byte and sets that port's `frameErr` bit. The receiver then waits for the line to return high before it looks for a new start bit. The next correctly framed byte on the same port clears the bit.
- R8: A low pulse on a receive line shorter than half a bit time produces no byte, no framing error and no count.
- R9: `cmdValid`, `cmdData` and `cmdPort` (0 = port 1, 1 = port 2) stay unchanged while `cmdValid` is high and `cmdReady` is low. A byte is consumed on a cycle where both are high.
- R10: `cmdLocal` is high for a byte from port 1 when `localIsFirst` is 1, and for a byte from port 2 when `localIsFirst` is 0.
- R11: When both ports have a byte waiting, the port that did not supply the previously issued byte goes first.
- R12: Each port holds one waiting byte behind the output register. A byte that completes while that port's slot is still occupied is dropped and counted in the port's drop counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateSel | input | 3 | Port 1 rate code |
| localIsFirst | input | 1 | 1: port 1 is local, 0: port 2 is local (tie high when unused) |
| rxIn | input | 2 | Receive lines, bit 0 = port 1, bit 1 = port 2 |
| txOut | output | 2 | Transmit lines, bit 0 = port 1, bit 1 = port 2 |
| cmdValid | output | 1 | Received byte available |
| cmdReady | input | 1 | Interpreter accepts the byte |
| cmdData | output | 8 | Received byte |
| cmdPort | output | 1 | Source port of the byte (0 = port 1) |
| cmdLocal | output | 1 | Byte came from the local port |
| portReady | output | 2 | Readiness interval over, per port |
| frameErr | output | 2 | Framing error flag, per port |
| dropCnt1 | output | CNT_W | Bytes dropped on port 1 |
| dropCnt2 | output | CNT_W | Bytes dropped on port 2 |

## Verification
The bench builds the block with CLK_HZ = 1,536,000, READY1_CYC = 6000 and READY2_CYC = 9000. With those values a 19200 bit/s bit lasts 80 cycles and a 1200 bit/s bit lasts 1280 cycles, so all five port 1 rates fit in the run. Both readiness edges also fall inside a few thousand cycles. That lets the bench watch the full greetings, inject bytes during each blackout, and then test slot overflow and port alternation after the blackouts end.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int NPORT = 2;
  localparam int OVS = 16;
  localparam logic [31:0] PORT2_TEXT = 32'h4154_2B69;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rxState_e;

  typedef struct packed {
    logic [NPORT-1:0]      txLoad;
    logic [NPORT-1:0][7:0] txByte;
  } txStrobe_t;

  typedef struct packed {
    logic [NPORT-1:0]      rxGood;
    logic [NPORT-1:0]      rxBad;
    logic [NPORT-1:0][7:0] rxByte;
    logic [NPORT-1:0]      txBusy;
  } dpStatus_t;

  function automatic logic [2:0] clampRate(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction
endpackage

// File: rtl/duart_datapath.sv
module duart_datapath
  import duart_pkg::*;
#(
  parameter int CLK_HZ     = 16_000_000,
  parameter int BAUD_MIN   = 1200,
  parameter int FIXED_BAUD = 19200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       rateSel,
  input  logic [NPORT-1:0] rxIn,
  input  txStrobe_t        strb,
  output logic [NPORT-1:0] txOut,
  output dpStatus_t        stat
);
  localparam int BASE_DIV = CLK_HZ / (BAUD_MIN * OVS);
  localparam int FIX_DIV  = CLK_HZ / (FIXED_BAUD * OVS);
  localparam int DIV_W    = $clog2(BASE_DIV + 1);

  logic [NPORT-1:0]      goodV, badV, busyV;
  logic [NPORT-1:0][7:0] byteV;

  for (genvar p = 0; p < NPORT; p++) begin : gPort
    logic [DIV_W-1:0] divVal, divCnt;
    logic             tick;
    logic [1:0]       syncQ;
    logic             rxS;
    rxState_e         rxSt;
    logic [3:0]       rxTick;
    logic [2:0]       rxBit;
    logic [7:0]       rxSh;
    logic             goodQ, badQ;
    logic             busy;
    logic [9:0]       txSh;
    logic [3:0]       txTick, txCnt;

    if (p == 0) begin : gSel
      assign divVal = DIV_W'(BASE_DIV) >> clampRate(rateSel);
    end else begin : gFix
      assign divVal = DIV_W'(FIX_DIV);
    end

    assign tick = (divCnt >= divVal - 1'b1);

    always_ff @(posedge clk) begin
      if (!rstN) divCnt <= '0;
      else if (tick) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= 2'b11;
      else syncQ <= {syncQ[0], rxIn[p]};
    end
    assign rxS = syncQ[1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxSt <= RX_IDLE; rxTick <= '0; rxBit <= '0; rxSh <= '0;
        goodQ <= 1'b0; badQ <= 1'b0;
      end else begin
        goodQ <= 1'b0;
        badQ  <= 1'b0;
        case (rxSt)
          RX_IDLE: if (!rxS) begin rxSt <= RX_START; rxTick <= '0; end
          RX_START: if (tick) begin
            if (rxS) rxSt <= RX_IDLE;
            else if (rxTick == 4'd7) begin rxSt <= RX_DATA; rxTick <= '0; rxBit <= '0; end
            else rxTick <= rxTick + 1'b1;
          end
          RX_DATA: if (tick) begin
            if (rxTick == 4'd15) begin
              rxTick <= '0;
              rxSh   <= {rxS, rxSh[7:1]};
              if (rxBit == 3'd7) rxSt <= RX_STOP;
              else rxBit <= rxBit + 1'b1;
            end else rxTick <= rxTick + 1'b1;
          end
          RX_STOP: if (tick) begin
            if (rxTick == 4'd15) begin
              rxTick <= '0;
              if (rxS) begin goodQ <= 1'b1; rxSt <= RX_IDLE; end
              else begin badQ <= 1'b1; rxSt <= RX_HOLD; end
            end else rxTick <= rxTick + 1'b1;
          end
          RX_HOLD: if (rxS) rxSt <= RX_IDLE;
          default: rxSt <= RX_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy <= 1'b0; txSh <= '1; txTick <= '0; txCnt <= '0;
      end else if (!busy) begin
        if (strb.txLoad[p]) begin
          busy <= 1'b1; txSh <= {1'b1, strb.txByte[p], 1'b0};
          txTick <= '0; txCnt <= '0;
        end
      end else if (tick) begin
        if (txTick == 4'd15) begin
          txTick <= '0;
          txSh   <= {1'b1, txSh[9:1]};
          if (txCnt == 4'd9) busy <= 1'b0;
          else txCnt <= txCnt + 1'b1;
        end else txTick <= txTick + 1'b1;
      end
    end

    assign txOut[p] = busy ? txSh[0] : 1'b1;
    assign goodV[p] = goodQ;
    assign badV[p]  = badQ;
    assign byteV[p] = rxSh;
    assign busyV[p] = busy;

    AST_TX_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      strb.txLoad[p] |-> !busy); // R4
    AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (busy && txCnt == 4'd9) |-> txOut[p]); // R3
    AST_RX_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
      !(goodQ && badQ)); // R7
  end

  assign stat.rxGood = goodV;
  assign stat.rxBad  = badV;
  assign stat.rxByte = byteV;
  assign stat.txBusy = busyV;
endmodule

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
#(
  parameter int READY1_CYC = 40_000_000,
  parameter int READY2_CYC = 240_000_000,
  parameter int TEXT_MAX   = 16,
  parameter logic [8*TEXT_MAX-1:0] VERSION_TEXT = "FE-1.3",
  parameter int VERSION_LEN = 6,
  parameter int CNT_W      = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStatus_t              stat,
  input  logic                   localIsFirst,
  input  logic                   cmdReady,
  output txStrobe_t              strb,
  output logic                   cmdValid,
  output logic [7:0]             cmdData,
  output logic                   cmdPort,
  output logic                   cmdLocal,
  output logic [NPORT-1:0]       portReady,
  output logic [NPORT-1:0]       frameErr,
  output logic [NPORT-1:0][CNT_W-1:0] dropCnt
);
  localparam int RDY_MAX = (READY1_CYC > READY2_CYC) ? READY1_CYC : READY2_CYC;
  localparam int RW      = $clog2(RDY_MAX + 1);
  localparam int BW      = $clog2(TEXT_MAX + 3);

  function automatic int readyLimit(input int p);
    return (p == 0) ? READY1_CYC : READY2_CYC;
  endfunction

  function automatic int bannerLen(input int p);
    return (p == 0) ? VERSION_LEN + 2 : 6;
  endfunction

  function automatic logic [7:0] bannerChar(input int p, input int idx);
    int tlen;
    logic [8*TEXT_MAX-1:0] txt;
    tlen = (p == 0) ? VERSION_LEN : 4;
    txt  = (p == 0) ? VERSION_TEXT : {{(8*TEXT_MAX-32){1'b0}}, PORT2_TEXT};
    if (idx == tlen) return 8'h0D;
    if (idx == tlen + 1) return 8'h0A;
    return 8'(txt >> (8 * (tlen - 1 - idx)));
  endfunction

  logic [NPORT-1:0][RW-1:0] rdyCnt;
  logic [NPORT-1:0][BW-1:0] bIdx;
  logic [NPORT-1:0]         loadV;
  logic [NPORT-1:0][7:0]    charV;
  logic [NPORT-1:0]         pend;
  logic [NPORT-1:0][7:0]    pendByte;
  logic                     outFull, outPort, lastPort;
  logic [7:0]               outData;
  logic                     loadOut, pick;

  // readiness timers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdyCnt <= '0; portReady <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (!portReady[p]) begin
          if (int'(rdyCnt[p]) >= readyLimit(p) - 1) portReady[p] <= 1'b1;
          else rdyCnt[p] <= rdyCnt[p] + 1'b1;
        end
      end
    end
  end

  // greeting sequencer
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      loadV[p] = (int'(bIdx[p]) < bannerLen(p)) && !stat.txBusy[p];
      charV[p] = bannerChar(p, int'(bIdx[p]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bIdx <= '0;
    else for (int p = 0; p < NPORT; p++) if (loadV[p]) bIdx[p] <= bIdx[p] + 1'b1;
  end

  assign strb.txLoad = loadV;
  assign strb.txByte = charV;

  // arbitration into the output register
  always_comb begin
    if (pend[0] && pend[1]) pick = ~lastPort;
    else pick = pend[1];
  end
  assign loadOut = (!outFull || cmdReady) && (pend != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0; pendByte <= '0; frameErr <= '0; dropCnt <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (stat.rxBad[p]) frameErr[p] <= 1'b1;
        else if (stat.rxGood[p]) frameErr[p] <= 1'b0;
        if (stat.rxGood[p]) begin
          if (!portReady[p] || (pend[p] && !(loadOut && int'(pick) == p)))
            dropCnt[p] <= dropCnt[p] + 1'b1;
          else begin
            pend[p] <= 1'b1; pendByte[p] <= stat.rxByte[p];
          end
        end else if (loadOut && int'(pick) == p) pend[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outFull <= 1'b0; outData <= '0; outPort <= 1'b0; lastPort <= 1'b1;
    end else if (loadOut) begin
      outFull <= 1'b1; outData <= pendByte[pick]; outPort <= pick; lastPort <= pick;
    end else if (cmdReady) outFull <= 1'b0;
  end

  assign cmdValid = outFull;
  assign cmdData  = outData;
  assign cmdPort  = outPort;
  assign cmdLocal = outFull && (outPort == !localIsFirst);

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData) && $stable(cmdPort))); // R9

  for (genvar g = 0; g < NPORT; g++) begin : gChk
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      portReady[g] |=> portReady[g]); // R5
    AST_BLACKOUT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
      !portReady[g] |-> !pend[g]); // R6
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
      $stable(dropCnt[g]) || (dropCnt[g] == CNT_W'($past(dropCnt[g]) + 1'b1))); // R12
  end
endmodule

// File: rtl/dual_uart_front.sv
module dual_uart_front
  import duart_pkg::*;
#(
  parameter int CLK_HZ      = 16_000_000,
  parameter int READY1_CYC  = 40_000_000,
  parameter int READY2_CYC  = 240_000_000,
  parameter int TEXT_MAX    = 16,
  parameter logic [8*TEXT_MAX-1:0] VERSION_TEXT = "FE-1.3",
  parameter int VERSION_LEN = 6,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       rateSel,
  input  logic             localIsFirst,
  input  logic [1:0]       rxIn,
  output logic [1:0]       txOut,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic [7:0]       cmdData,
  output logic             cmdPort,
  output logic             cmdLocal,
  output logic [1:0]       portReady,
  output logic [1:0]       frameErr,
  output logic [CNT_W-1:0] dropCnt1,
  output logic [CNT_W-1:0] dropCnt2
);
  txStrobe_t strb;
  dpStatus_t stat;
  logic [NPORT-1:0][CNT_W-1:0] dropCnt;

  duart_datapath #(.CLK_HZ(CLK_HZ)) dp_i (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .rxIn(rxIn),
    .strb(strb), .txOut(txOut), .stat(stat)
  );

  duart_ctrl #(
    .READY1_CYC(READY1_CYC), .READY2_CYC(READY2_CYC), .TEXT_MAX(TEXT_MAX),
    .VERSION_TEXT(VERSION_TEXT), .VERSION_LEN(VERSION_LEN), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .stat(stat), .localIsFirst(localIsFirst),
    .cmdReady(cmdReady), .strb(strb), .cmdValid(cmdValid), .cmdData(cmdData),
    .cmdPort(cmdPort), .cmdLocal(cmdLocal), .portReady(portReady),
    .frameErr(frameErr), .dropCnt(dropCnt)
  );

  assign dropCnt1 = dropCnt[0];
  assign dropCnt2 = dropCnt[1];
endmodule

// File: tb/dual_uart_front_tb_top.sv
module dual_uart_front_tb_top;
  localparam int CLKHZ = 1_536_000;
  localparam int RDY1  = 6000;
  localparam int RDY2  = 9000;
  localparam int B19   = 80;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] rateSel = 3'd4;
  logic localIsFirst = 1'b1;
  logic [1:0] rxDrv = 2'b11;
  logic [1:0] txOut;
  logic cmdValid, cmdReady, cmdPort, cmdLocal;
  logic [7:0] cmdData;
  logic [1:0] portReady, frameErr;
  logic [CW-1:0] dropCnt1, dropCnt2;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_uart_front #(.CLK_HZ(CLKHZ), .READY1_CYC(RDY1), .READY2_CYC(RDY2), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .localIsFirst(localIsFirst),
    .rxIn(rxDrv), .txOut(txOut), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdData(cmdData), .cmdPort(cmdPort), .cmdLocal(cmdLocal),
    .portReady(portReady), .frameErr(frameErr), .dropCnt1(dropCnt1), .dropCnt2(dropCnt2)
  );

  initial cmdReady = 1'b0;

  always @(posedge clk) if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input int p, input logic [7:0] b, input int bitCyc, input bit goodStop);
    rxDrv[p] = 1'b0; repeat (bitCyc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxDrv[p] = b[i]; repeat (bitCyc) @(negedge clk); end
    rxDrv[p] = goodStop; repeat (bitCyc) @(negedge clk);
    rxDrv[p] = 1'b1; repeat (bitCyc) @(negedge clk);
  endtask

  task automatic recvByte(input int p, input int bitCyc, output logic [7:0] b, output logic stopOk);
    @(negedge clk);
    while (txOut[p]) @(negedge clk);
    repeat (bitCyc / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin repeat (bitCyc) @(negedge clk); b[i] = txOut[p]; end
    repeat (bitCyc) @(negedge clk);
    stopOk = txOut[p];
  endtask

  task automatic pop();
    cmdReady = 1'b1; @(negedge clk); cmdReady = 1'b0; @(negedge clk);
  endtask

  task automatic expectCmd(input string req, input logic [7:0] d, input logic prt, input logic loc);
    chk(req, "cmdValid", cmdValid, 1'b1);
    chk(req, "cmdData", cmdData, d);
    chk(req, "cmdPort", cmdPort, prt);
    chk(req, "cmdLocal", cmdLocal, loc);
  endtask

  function automatic logic [7:0] expBanner(input int p, input int i);
    string t;
    t = (p == 0) ? "FE-1.3" : "AT+i";
    if (i == t.len()) return 8'h0D;
    if (i == t.len() + 1) return 8'h0A;
    return t[i];
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk("R3", "txOut idle in reset", txOut, 2'b11);
    chk("R9", "cmdValid in reset", cmdValid, 1'b0);
    chk("R5", "portReady in reset", portReady, 2'b00);
    chk("R7", "frameErr in reset", frameErr, 2'b00);
    chk("R6", "drop counts in reset", {dropCnt1, dropCnt2}, '0);
  endtask

  task automatic test_banner_blackout();
    fork
      begin : port1Banner
        logic [7:0] b; logic s;
        for (int i = 0; i < 8; i++) begin
          recvByte(0, B19, b, s);
          chk("R4", "port1 greeting char", b, expBanner(0, i));
          chk("R3", "port1 stop bit", s, 1'b1);
        end
      end
      begin : port2Banner
        logic [7:0] b; logic s;
        for (int i = 0; i < 6; i++) begin
          recvByte(1, B19, b, s);
          chk("R4", "port2 greeting char", b, expBanner(1, i));
        end
      end
      begin : blackout
        repeat (100) @(negedge clk);
        sendByte(0, 8'h55, B19, 1'b1);
        wait (cyc >= RDY1 - 10); @(negedge clk);
        chk("R5", "port1 not ready before limit", portReady[0], 1'b0);
        wait (cyc >= RDY1 + 10); @(negedge clk);
        chk("R5", "port1 ready after limit", portReady[0], 1'b1);
        wait (cyc >= 7000); @(negedge clk);
        sendByte(1, 8'h66, B19, 1'b1);
        wait (cyc >= RDY2 - 10); @(negedge clk);
        chk("R5", "port2 not ready before limit", portReady[1], 1'b0);
        wait (cyc >= RDY2 + 10); @(negedge clk);
        chk("R5", "port2 ready after limit", portReady[1], 1'b1);
      end
    join
    @(negedge clk);
    chk("R6", "port1 blackout drop", dropCnt1, 8'd1);
    chk("R6", "port2 blackout drop", dropCnt2, 8'd1);
    chk("R6", "nothing presented from blackout", cmdValid, 1'b0);
    chk("R4", "lines idle after greeting", txOut, 2'b11);
  endtask

  task automatic test_hold_local();
    sendByte(0, 8'hA5, B19, 1'b1);
    expectCmd("R9", 8'hA5, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    expectCmd("R9", 8'hA5, 1'b0, 1'b1);
    pop();
    chk("R9", "consumed", cmdValid, 1'b0);
    sendByte(1, 8'h3C, B19, 1'b1);
    expectCmd("R10", 8'h3C, 1'b1, 1'b0);
    localIsFirst = 1'b0; @(negedge clk);
    chk("R10", "port2 local when select low", cmdLocal, 1'b1);
    pop();
    sendByte(0, 8'hC3, B19, 1'b1);
    expectCmd("R10", 8'hC3, 1'b0, 1'b0);
    pop();
    localIsFirst = 1'b1;
  endtask

  task automatic test_rates();
    rateSel = 3'd3; @(negedge clk);
    sendByte(0, 8'h5A, 2 * B19, 1'b1);
    expectCmd("R1", 8'h5A, 1'b0, 1'b1); pop();
    rateSel = 3'd0; @(negedge clk);
    sendByte(0, 8'h81, 16 * B19, 1'b1);
    expectCmd("R1", 8'h81, 1'b0, 1'b1); pop();
    sendByte(1, 8'h92, B19, 1'b1);
    expectCmd("R2", 8'h92, 1'b1, 1'b0); pop();
    rateSel = 3'd7; @(negedge clk);
    sendByte(0, 8'h4E, B19, 1'b1);
    expectCmd("R1", 8'h4E, 1'b0, 1'b1); pop();
    rateSel = 3'd4;
  endtask

  task automatic test_framing_glitch();
    logic [CW-1:0] d1;
    d1 = dropCnt1;
    sendByte(0, 8'h77, B19, 1'b0);
    chk("R7", "bad frame not presented", cmdValid, 1'b0);
    chk("R7", "frameErr set", frameErr, 2'b01);
    sendByte(0, 8'h11, B19, 1'b1);
    expectCmd("R7", 8'h11, 1'b0, 1'b1);
    chk("R7", "frameErr cleared", frameErr, 2'b00);
    pop();
    rxDrv[0] = 1'b0; repeat (20) @(negedge clk);
    rxDrv[0] = 1'b1; repeat (300) @(negedge clk);
    chk("R8", "glitch gives no byte", cmdValid, 1'b0);
    chk("R8", "glitch gives no frame error", frameErr, 2'b00);
    chk("R8", "glitch gives no count", dropCnt1, d1);
  endtask

  task automatic test_overflow_alternation();
    logic [CW-1:0] d1;
    d1 = dropCnt1;
    sendByte(0, 8'h01, B19, 1'b1);
    sendByte(0, 8'h03, B19, 1'b1);
    sendByte(1, 8'h02, B19, 1'b1);
    sendByte(0, 8'h04, B19, 1'b1);
    chk("R12", "overflow counted", dropCnt1, CW'(d1 + 1));
    expectCmd("R11", 8'h01, 1'b0, 1'b1); pop();
    expectCmd("R11", 8'h02, 1'b1, 1'b0); pop();
    expectCmd("R11", 8'h03, 1'b0, 1'b1); pop();
    chk("R12", "overflow byte never shown", cmdValid, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    test_banner_blackout();
    test_hold_local();
    test_rates();
    test_framing_glitch();
    test_overflow_alternation();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule